// File: doc/BRIEF.md
# Mains Zero-Cross Falling-Edge Debouncer

This block cleans up the digital output of a mains zero-crossing comparator before the timing recovery logic uses it. The raw comparator bit is asynchronous and bounces around each crossing, so it first passes through a synchronizer clocked by the 24 MHz system clock. It then goes through a filter that treats the two directions differently. A change from low to high reaches the cleaned output at once. A change from high to low is accepted only after the synchronized input has stayed low for a full debounce window.

The default window is 18,000 cycles, which is 0.75 ms at 24 MHz. That sits inside the 0.5 ms to 1 ms band the filter must meet, and it is far shorter than the 8.3 ms to 10 ms half period of 50 Hz or 60 Hz mains. Rising crossings carry the timing reference, so they see no filter delay. The block also emits a one-cycle strobe on each accepted rising crossing, which feeds a downstream phase tracker.

Top module: `zc_debounce_top`

## Requirements
- R1: While synchronous reset is asserted, and on the first cycle after it, `zc_clean` is 0 and `zc_rise` is 0. The debounce count also restarts from zero.
- R2: A raw input that goes from 0 to 1 is visible on `zc_clean` as 1 two clock cycles later (two synchronizer flops plus the output register) with no added filter delay. Counting the register stages: raw set before edge t gives an output of 1 after edge t+2.
- R3: When `zc_clean` is 1 and the raw input goes to 0 before edge t and stays 0, `zc_clean` goes to 0 after edge t+DEBOUNCE_CYCLES+1.
- R4: A low interval on the raw input that is shorter than DEBOUNCE_CYCLES cycles leaves `zc_clean` at 1. An interval of exactly DEBOUNCE_CYCLES-1 cycles does not cause a fall, and an interval of exactly DEBOUNCE_CYCLES cycles does.
- R5: The debounce count restarts whenever the synchronized input returns to 1. Two short low intervals separated by a one-cycle high cause no fall, even when their combined length exceeds the window.
- R6: `zc_rise` is 1 for exactly one cycle on each 0-to-1 change of `zc_clean`, in the same cycle that `zc_clean` first reads 1. It is 0 at all other times.
- R7: Bounces of the raw input while `zc_clean` is 1 (brief drops to 0, then a return to 1) produce no `zc_rise` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (24 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| zc_raw | input | 1 | Asynchronous thresholded comparator bit |
| zc_clean | output | 1 | Debounced zero-cross level |
| zc_rise | output | 1 | One-cycle strobe on each accepted rising crossing |

## Verification
The bench builds the block with DEBOUNCE_CYCLES set to 20 instead of 18,000. A full window and the cases just around it are then only a few dozen cycles long. This makes it cheap to test both window boundaries (N-1 and N low cycles), two short low intervals split by a single high cycle, and bounces during the high phase. The bench predicts the cycle of every rise strobe and every fall of the cleaned level from R2 and R3. It then matches each observed event against that prediction and reports any event that was not predicted.

// File: rtl/zc_pkg.sv
package zc_pkg;

    // Default falling-edge window: 0.75 ms at 24 MHz
    localparam int unsigned ZC_DEFAULT_WINDOW = 18000;

    // Minimum synchronizer depth
    localparam int unsigned ZC_SYNC_STAGES = 2;

    // Width needed to count 0 .. n-1
    function automatic int unsigned zc_cnt_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    typedef enum logic {
        ZC_LOW  = 1'b0,
        ZC_HIGH = 1'b1
    } zc_level_e;

    typedef struct packed {
        zc_level_e level;
        logic      rise;
    } zc_out_s;

endpackage

// File: rtl/zc_sync.sv
module zc_sync #(
    parameter int unsigned STAGES = zc_pkg::ZC_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/zc_fall_filter.sv
module zc_fall_filter
    import zc_pkg::*;
#(
    parameter int unsigned WINDOW = ZC_DEFAULT_WINDOW
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_in,
    output zc_level_e level
);
    localparam int unsigned CW = zc_cnt_width(WINDOW);
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    logic [CW-1:0] cnt_q;
    zc_level_e     level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= ZC_LOW;
            cnt_q   <= '0;
        end else if (sync_in) begin
            level_q <= ZC_HIGH;
            cnt_q   <= '0;
        end else if (level_q == ZC_HIGH) begin
            if (cnt_q == LAST) begin
                level_q <= ZC_LOW;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign level = level_q;

    // R1: reset clears the level
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> (level_q == ZC_LOW));

    // R2: a high synchronized input forces the level high next cycle
    assert_rise_immediate_R2: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> (level_q == ZC_HIGH));

    // R3: a fall only follows a synchronized low input
    assert_fall_after_low_R3: assert property (@(posedge clk) disable iff (rst)
        (level_q == ZC_LOW) && $past(level_q == ZC_HIGH) |-> !$past(sync_in));

    // R5: count returns to zero whenever input is high
    assert_count_restart_R5: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> (cnt_q == '0));

    // R4: the count never leaves its window
    assert_count_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/zc_edge_strobe.sv
module zc_edge_strobe
    import zc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  zc_level_e level,
    output zc_out_s   out
);
    zc_level_e prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= ZC_LOW;
        end else begin
            prev_q <= level;
        end
    end

    always_comb begin
        out.level = level;
        out.rise  = (level == ZC_HIGH) && (prev_q == ZC_LOW);
    end

    // R6: the strobe lasts a single cycle
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
        out.rise |=> !out.rise);

    // R6: the strobe only appears together with a high level
    assert_strobe_with_high_R6: assert property (@(posedge clk) disable iff (rst)
        out.rise |-> (out.level == ZC_HIGH));
endmodule

// File: rtl/zc_debounce_top.sv
module zc_debounce_top
    import zc_pkg::*;
#(
    parameter int unsigned DEBOUNCE_CYCLES = ZC_DEFAULT_WINDOW,
    parameter int unsigned SYNC_STAGES     = ZC_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic zc_raw,
    output logic zc_clean,
    output logic zc_rise
);
    logic      sync_bit;
    zc_level_e filt_level;
    zc_out_s   strobe_out;

    zc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (zc_raw),
        .q_sync  (sync_bit)
    );

    zc_fall_filter #(.WINDOW(DEBOUNCE_CYCLES)) u_filter (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_bit),
        .level   (filt_level)
    );

    zc_edge_strobe u_strobe (
        .clk   (clk),
        .rst   (rst),
        .level (filt_level),
        .out   (strobe_out)
    );

    assign zc_clean = (strobe_out.level == ZC_HIGH);
    assign zc_rise  = strobe_out.rise;

    // R1: outputs quiet in the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!zc_clean && !zc_rise));

    // R7: no strobe while the level was already high
    assert_no_strobe_when_high_R7: assert property (@(posedge clk) disable iff (rst)
        $past(zc_clean) |-> !zc_rise);
endmodule

// File: tb/zc_debounce_top_tb.sv
module zc_debounce_top_tb;
    localparam int unsigned N = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic zc_raw = 1'b0;
    logic zc_clean;
    logic zc_rise;

    int cyc = 0;
    int vectors = 0;
    int fails = 0;
    bit exp_clean = 1'b0;
    bit mon_en = 1'b0;
    bit prev_clean = 1'b0;

    int exp_cyc[$];
    bit exp_rise[$];   // 1 = rise strobe, 0 = fall of level

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    zc_debounce_top #(.DEBOUNCE_CYCLES(N)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .zc_raw   (zc_raw),
        .zc_clean (zc_clean),
        .zc_rise  (zc_rise)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Driver: apply a level for len cycles and predict events (R2, R3, R4, R5, R7)
    task automatic drive(input bit level, input int len);
        int t;
        @(negedge clk);
        zc_raw = level;
        t = cyc + 1;
        if (level) begin
            if (!exp_clean) begin
                exp_cyc.push_back(t + 2);   // R2 latency, R6 strobe
                exp_rise.push_back(1'b1);
            end
            exp_clean = 1'b1;                // R7: bounce while high -> no event
        end else if (exp_clean && len >= N) begin
            exp_cyc.push_back(t + N + 1);   // R3 fall latency
            exp_rise.push_back(1'b0);
            exp_clean = 1'b0;
        end
        repeat (len - 1) @(negedge clk);
    endtask

    // Monitor: match observed events against predictions
    always @(negedge clk) begin
        if (mon_en) begin
            if (zc_rise || (prev_clean && !zc_clean)) begin
                if (exp_cyc.size() == 0) begin
                    check(1'b0, "R6/R7 unexpected event", cyc, -1);
                end else begin
                    int ec;
                    bit er;
                    ec = exp_cyc.pop_front();
                    er = exp_rise.pop_front();
                    check(ec == cyc, er ? "R2/R6 rise timing" : "R3/R4 fall timing", cyc, ec);
                    check(er == zc_rise, "R6 event kind", int'(zc_rise), int'(er));
                    if (zc_rise) check(zc_clean, "R6 strobe with high level", int'(zc_clean), 1);
                end
            end
            if (exp_cyc.size() != 0 && exp_cyc[0] < cyc) begin
                check(1'b0, "R2/R3 missing event", cyc, exp_cyc[0]);
                void'(exp_cyc.pop_front());
                void'(exp_rise.pop_front());
            end
        end
        prev_clean = zc_clean;
    end

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                check(zc_clean == 1'b0, "R1 reset level", int'(zc_clean), 0);
                check(zc_rise == 1'b0, "R1 reset strobe", int'(zc_rise), 0);
                rst = 1'b0;
                mon_en = 1'b1;
                repeat (8) @(negedge clk);
                check(zc_clean == 1'b0, "R1 idle low after reset", int'(zc_clean), 0);

                drive(1, 30);            // R2 rise
                drive(0, 5);             // R4 short drop
                drive(1, 3);             // R7 bounce high
                drive(0, 2);
                drive(1, 2);             // R7
                drive(0, 25);            // R3 fall
                drive(1, 12);            // R2 rise
                drive(0, N - 2);         // R5 first part
                drive(1, 1);
                drive(0, N - 2);         // R5 second part, total > N
                drive(1, 10);
                check(zc_clean == 1'b1, "R5 restart kept level high", int'(zc_clean), 1);
                drive(0, N - 1);         // R4 boundary, no fall
                drive(1, 6);
                check(zc_clean == 1'b1, "R4 N-1 low kept level high", int'(zc_clean), 1);
                drive(0, N);             // R4 boundary, fall
                drive(1, 10);            // rise right after
                drive(0, 40);            // R3 fall
                drive(1, 1);             // single-cycle high passes unfiltered (R2)
                drive(0, 30);
                drive(1, 15);
                repeat (5) @(negedge clk);
                check(exp_cyc.size() == 0, "R3 all predicted events seen", exp_cyc.size(), 0);

                // R1: reset while high
                mon_en = 1'b0;
                rst = 1'b1;
                @(negedge clk);
                @(negedge clk);
                check(zc_clean == 1'b0, "R1 reset clears high level", int'(zc_clean), 0);
                check(zc_rise == 1'b0, "R1 reset strobe low", int'(zc_rise), 0);
            end
            begin
                repeat (50000) @(posedge clk);
                check(1'b0, "watchdog expired", cyc, 0);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule